// File: doc/BRIEF.md
# Write-Only Two-Wire Register Slave

This block is a write-only slave on a two-wire serial bus whose data line is open-drain. A fast system clock samples both bus lines. The block then finds start and stop conditions and reads the bits on rising bus-clock edges. It checks an 8-bit header that holds a 7-bit device address and a direction bit. If the header is a write to its own address, it takes in exactly two more bytes and acknowledges each of them.

The two bytes form a 16-bit control word. The upper 7 bits name a register and the lower 9 bits are that register's new value. When the second byte has been acknowledged, the block raises a one-cycle write strobe carrying the register index and the value. The block stays silent on a foreign address or a read request and goes back to idle. Any start or stop condition that arrives while a transfer is open ends the transfer with no write.

Top module: `twowire_reg_slave`

## Requirements
- R1: After reset the data-line pull-down (`sda_drive_low`) is released and `wr_valid` is low.
- R2: A start condition (data falls while the bus clock is high) seen while idle opens an address phase. Eight bits are then taken on rising bus-clock edges, most significant first: bits 7..1 are the device address and bit 0 is the direction (0 = write).
- R3: A header holding address 7'b0011010 with direction 0 is acknowledged. The block pulls data low from the bus-clock fall after the eighth bit until the next bus-clock fall.
- R4: A header with any other address, or with direction 1, gets no acknowledge. The block returns to idle and the following bytes get no acknowledge and cause no write.
- R5: After an accepted header, the first byte supplies word bits 15..8 and the second byte supplies word bits 7..0. Each byte is acknowledged in its ninth clock.
- R6: `sda_drive_low` is low during every bit a master sends, and it never changes while the synchronised bus clock stays high.
- R7: `wr_valid` pulses for exactly one system-clock cycle after the second acknowledge. `wr_reg` is word bits 15..9 and `wr_data` is word bits 8..0.
- R8: A stop condition (data rises while the bus clock is high) during an open transfer returns the block to idle, and no write happens.
- R9: A start condition during an open transfer returns the block to idle rather than starting a new header. Later bytes get no acknowledge and no write happens.
- R10: After a finished or aborted transfer, the block accepts the next start and a valid transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin (wired-AND) |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls data low |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_reg | output | 7 | Register index of the write |
| wr_data | output | 9 | Value to write |

## Verification
The hardest state to reach is a transfer that is interrupted in the middle of a byte by a stray start or stop. In that case the block must drop its partly shifted byte, and its idle state must then ignore every bit that follows. The bench reaches this by driving the two lines directly. It raises the bus clock with data high and pulls data low a few bits into the first data byte. In another case it issues a stop part-way through the second byte. It then checks that no acknowledge appears and no strobe fires, and that a clean transfer right afterwards is accepted.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 7;
    localparam int DATA_W = 9;
    localparam int WORD_W = REG_W + DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDR_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK
    } tw_state_e;

    typedef struct packed {
        logic [REG_W-1:0]  reg_idx;
        logic [DATA_W-1:0] value;
    } tw_word_t;

    function automatic logic hdr_accept(input logic [BYTE_W-1:0] hdr,
                                        input logic [ADDR_W-1:0] dev);
        return (hdr[BYTE_W-1:1] == dev) && !hdr[0];
    endfunction

    function automatic logic is_ack_state(input tw_state_e s);
        return (s == ST_HDR_ACK) || (s == ST_HI_ACK) || (s == ST_LO_ACK);
    endfunction

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 7'b0011010
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    input  logic     scl_rise,
    input  logic     scl_fall,
    input  logic     start_det,
    input  logic     stop_det,
    output logic     ack_drive,
    output logic     wr_valid,
    output tw_word_t wr_word
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    tw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] hi_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            hi_byte  <= '0;
            wr_valid <= 1'b0;
            wr_word  <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (stop_det) begin
                state <= ST_IDLE;
            end else if (start_det) begin
                state <= (state == ST_IDLE) ? ST_HDR : ST_IDLE;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_HDR, ST_HI, ST_LO: begin
                        if (scl_rise && cnt < FULL) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall && cnt == FULL) begin
                            cnt <= '0;
                            if (state == ST_HDR)
                                state <= hdr_accept(sh, DEV_ADDR) ? ST_HDR_ACK : ST_IDLE;
                            else if (state == ST_HI) begin
                                hi_byte <= sh;
                                state   <= ST_HI_ACK;
                            end else
                                state <= ST_LO_ACK;
                        end
                    end
                    ST_HDR_ACK: if (scl_fall) state <= ST_HI;
                    ST_HI_ACK:  if (scl_fall) state <= ST_LO;
                    ST_LO_ACK: begin
                        if (scl_fall) begin
                            state    <= ST_IDLE;
                            wr_valid <= 1'b1;
                            wr_word  <= tw_word_t'({hi_byte, sh});
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign ack_drive = is_ack_state(state);

    // R7
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
    // R6
    a_r6_drive_steady_high: assert property (@(posedge clk) disable iff (rst)
        (scl_s && $past(scl_s)) |-> $stable(ack_drive));
    // R8
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE && !ack_drive));
    // R9
    a_r9_start_aborts: assert property (@(posedge clk) disable iff (rst)
        (start_det && state != ST_IDLE) |=> state == ST_IDLE);
    // R2
    a_r2_start_opens: assert property (@(posedge clk) disable iff (rst)
        (start_det && !stop_det && state == ST_IDLE) |=> state == ST_HDR);
    // R4
    a_r4_read_rejected: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HDR && scl_fall && cnt == FULL && sh[0] && !start_det && !stop_det)
        |=> state == ST_IDLE);

endmodule

// File: rtl/twowire_reg_slave.sv
module twowire_reg_slave
    import tw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'b0011010,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic              wr_valid,
    output logic [REG_W-1:0]  wr_reg,
    output logic [DATA_W-1:0] wr_data
);
    logic     scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    tw_word_t word;

    tw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_drive (sda_drive_low),
        .wr_valid  (wr_valid),
        .wr_word   (word)
    );

    assign wr_reg  = word.reg_idx;
    assign wr_data = word.value;

    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!sda_drive_low && !wr_valid));

endmodule

// File: tb/twowire_reg_slave_tb.sv
module twowire_reg_slave_tb;
    localparam logic [6:0] DEV = 7'b0011010;
    localparam int H = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_drive_low, wr_valid;
    logic [6:0] wr_reg;
    logic [8:0] wr_data;

    assign sda_line = sda_m & ~sda_drive_low;

    twowire_reg_slave u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_drive_low(sda_drive_low), .wr_valid(wr_valid),
        .wr_reg(wr_reg), .wr_data(wr_data)
    );

    int errors = 0, checks = 0, wcount = 0;
    logic [6:0] last_reg;
    logic [8:0] last_data;
    bit done = 0;

    always @(posedge clk) begin
        if (wr_valid) begin
            wcount    = wcount + 1;
            last_reg  = wr_reg;
            last_data = wr_data;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_ack(input logic [6:0] a, input logic rw);
        return (a == DEV) && !rw;
    endfunction

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wt(H);
        sda_m = 0; wt(H);
        scl_m = 0; wt(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 0; wt(H/2);
        scl_m = 1; wt(H);
        sda_m = 1; wt(H);
    endtask

    task automatic bit_x(input logic b, output logic seen, output logic drv);
        sda_m = b; wt(H/2);
        scl_m = 1; wt(H/2);
        seen = !sda_line;
        drv  = sda_drive_low;
        wt(H/2);
        scl_m = 0; wt(H/2);
    endtask

    task automatic byte_x(input logic [7:0] v, output logic ack, inout logic rel_err);
        logic s, d;
        for (int i = 7; i >= 0; i--) begin
            bit_x(v[i], s, d);
            if (d) rel_err = 1;
        end
        bit_x(1'b1, ack, d);
    endtask

    task automatic xfer(input logic [6:0] da, input logic rw, input logic [15:0] w);
        logic a0, a1, a2, rel;
        logic e;
        int base;
        rel = 0; base = wcount; e = exp_ack(da, rw);
        bus_start();
        byte_x({da, rw}, a0, rel);
        chk(a0 == e, "R2/R3/R4 header ack", int'(a0), int'(e));
        byte_x(w[15:8], a1, rel);
        chk(a1 == e, "R5 first byte ack", int'(a1), int'(e));
        byte_x(w[7:0], a2, rel);
        chk(a2 == e, "R5 second byte ack", int'(a2), int'(e));
        bus_stop();
        wt(8);
        chk((wcount - base) == int'(e), "R7/R4 write count", wcount - base, int'(e));
        if (e) begin
            chk(last_reg == w[15:9], "R7 register index", int'(last_reg), int'(w[15:9]));
            chk(last_data == w[8:0], "R7 value", int'(last_data), int'(w[8:0]));
        end
        chk(!rel, "R6 released during master bits", int'(rel), 0);
    endtask

    initial begin
        logic a, rel, s, d;
        logic [15:0] w;
        logic [6:0]  da;
        int base, sel;
        void'($urandom(32'h5eed));
        wt(5);
        rst = 0;
        wt(2);
        chk(!sda_drive_low, "R1 drive released", int'(sda_drive_low), 0);
        chk(!wr_valid && wcount == 0, "R1 no strobe", wcount, 0);

        xfer(DEV, 1'b0, 16'hFFFF);
        xfer(DEV, 1'b0, 16'h0000);
        xfer(DEV, 1'b0, 16'h35A7);
        xfer(DEV ^ 7'h01, 1'b0, 16'h1234);
        xfer(DEV, 1'b1, 16'h4321);
        xfer(DEV, 1'b0, 16'h8001);

        // R9: stray start inside first data byte
        rel = 0; base = wcount;
        bus_start();
        byte_x({DEV, 1'b0}, a, rel);
        chk(a, "R9 header ack before abort", int'(a), 1);
        bit_x(1'b1, s, d); bit_x(1'b0, s, d); bit_x(1'b1, s, d);
        sda_m = 1; wt(H/2); scl_m = 1; wt(H);
        sda_m = 0; wt(H); scl_m = 0; wt(H/2);
        byte_x(8'hA5, a, rel);
        chk(!a, "R9 no ack after stray start", int'(a), 0);
        byte_x(8'h3C, a, rel);
        chk(!a, "R9 no ack on later byte", int'(a), 0);
        bus_stop(); wt(8);
        chk(wcount == base, "R9 no write", wcount - base, 0);
        chk(!sda_drive_low && !rel, "R9 drive released", int'(sda_drive_low), 0);
        xfer(DEV, 1'b0, 16'h5AA5); // R10

        // R8: stop inside second data byte
        rel = 0; base = wcount;
        bus_start();
        byte_x({DEV, 1'b0}, a, rel);
        byte_x(8'h77, a, rel);
        chk(a, "R8 first byte ack before abort", int'(a), 1);
        bit_x(1'b0, s, d); bit_x(1'b1, s, d); bit_x(1'b1, s, d); bit_x(1'b0, s, d);
        bus_stop(); wt(8);
        chk(wcount == base, "R8 no write after stop", wcount - base, 0);
        chk(!sda_drive_low, "R8 drive released", int'(sda_drive_low), 0);
        xfer(DEV, 1'b0, 16'hC3E1); // R10

        for (int i = 0; i < 24; i++) begin
            sel = int'($urandom % 4);
            w   = 16'($urandom);
            da  = DEV;
            if (sel == 2) begin
                da = 7'($urandom);
                if (da == DEV) da = da ^ 7'h40;
            end
            xfer(da, sel == 3, w);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule